// File: doc/BRIEF.md
# Calendar Clock Register Window

This block is a free-running time-of-day and calendar counter exposed to an 8-bit processor as a small read-only register window. A prescaler divides the system clock down to a one-millisecond tick. On each tick a chain of counters advances through milliseconds, seconds, minutes, hours, days, months and a 16-bit year. Month length follows a divisible-by-four leap rule.

Software reads the time one byte at a time. A read of offset 0 copies every field into a snapshot. Offsets 1 to 8 then return bytes from that snapshot, so a carry between two byte reads cannot tear a multi-byte value. Writes have no effect, and the bus reset clears only the read-data register. Only a separate power-on reset changes the time, and it loads a default date set by parameters.

Top module: `cal_clock_regs`

## Requirements
- R1: A read access (rd_en high, wr_en low, bus_rst_n high) drives rd_data on the next clock edge. Offset 0 returns the live year bits 7:0, and offset 1 returns the snapshot year bits 15:8.
- R2: Offsets 2 to 6 return the snapshot month (1..12), day (1..31), hour (0..23), minute (0..59) and second (0..59), in that order, each as a plain binary byte.
- R3: Offset 7 returns bits 7:0 of the snapshot millisecond count (0..999), and offset 8 returns bits 9:8 in its two low bits with zeros above.
- R4: The millisecond count advances once every CYC_PER_MS clock cycles. Each field carries into the next above it when it passes its upper limit: 999 ms, 59 s, 59 min, 23 h, last day of month, month 12. The 16-bit year increments.
- R5: The day wraps to 1 after day 30 in months 4, 6, 9 and 11, and after day 31 in the other months except February. February ends at day 29 when year bits 1:0 are zero, and at day 28 otherwise.
- R6: A read at offset 0 loads every field into the snapshot in the same edge. Reads at offsets 1 to 8 return the snapshot as it was at the last offset-0 read or power-on reset, whatever the counters have done since.
- R7: A read access at any offset above 8 returns zero.
- R8: A cycle with wr_en high performs no access, whatever rd_en and addr are. rd_data, the snapshot and the running time are all unchanged by it.
- R9: While bus_rst_n is low, rd_data is cleared to zero on the next edge, no access takes place, and the time keeps running.
- R10: While por_n is low, the time and the snapshot load the INIT_* parameter values, the prescaler restarts and rd_data clears to zero.
- R11: In a cycle with no access, rd_data holds its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; loads the default date |
| bus_rst_n | input | 1 | Bus reset, synchronous, active low; clears only rd_data |
| rd_en | input | 1 | Read strobe for one byte access |
| wr_en | input | 1 | Write strobe; the write is discarded and the cycle performs no access |
| addr | input | ADDR_W | Byte offset within the window |
| rd_data | output | 8 | Registered read data |

## Verification
The assertions take for granted that por_n is held low on the first clock edges. The prescaler and the calendar therefore start from a known default and are never compared against undefined state. They also take rd_en, wr_en, addr and bus_rst_n to be stable around each rising edge. The bench drives every input on the falling edge and holds power-on reset low for several cycles at the start and once more in mid-run. The default dates are chosen so that the short run crosses a leap-day boundary and a year boundary.

// File: rtl/caltime_pkg.sv
// Package caltime_pkg
// Shared calendar record, field limits and the month-length function.
// Assumes a Gregorian-style month table with a divisible-by-four leap rule.
package caltime_pkg;

    localparam int BYTE_W     = 8;
    localparam int REG_COUNT  = 9;
    localparam int MS_LAST    = 999;
    localparam int SEC_LAST   = 59;
    localparam int MIN_LAST   = 59;
    localparam int HOUR_LAST  = 23;
    localparam int MONTH_LAST = 12;

    typedef struct packed {
        logic [15:0] year;
        logic [3:0]  month;
        logic [4:0]  day;
        logic [4:0]  hour;
        logic [5:0]  minute;
        logic [5:0]  second;
        logic [9:0]  milli;
    } cal_time_t;

    // Number of days in month m of year y.
    function automatic logic [4:0] month_days(input logic [3:0] m, input logic [15:0] y);
        logic [4:0] d;
        case (m)
            4'd2:                      d = (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   d = 5'd30;
            default:                   d = 5'd31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
// Module cal_prescaler
// Divides the system clock into a single-cycle millisecond tick.
// Assumes CYC_PER_MS >= 2. The tick is high in the last cycle of each period.
module cal_prescaler #(
    parameter int CYC_PER_MS = 4
) (
    input  logic clk,
    input  logic por_n,
    output logic tick
);
    localparam int CW = $clog2(CYC_PER_MS + 1);
    localparam logic [CW-1:0] LAST = CW'(CYC_PER_MS - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    // Count cycles within one millisecond; restart after the tick.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/cal_counters.sv
// Module cal_counters
// Cascaded calendar counters advanced by the millisecond tick.
// Assumes the fields always hold legal values (guaranteed from power-on reset).
module cal_counters
    import caltime_pkg::*;
#(
    parameter cal_time_t INIT_T = '0
) (
    input  logic      clk,
    input  logic      por_n,
    input  logic      tick,
    output cal_time_t now
);
    cal_time_t t_q;
    cal_time_t t_nxt;
    logic [4:0] last_day;

    assign last_day = month_days(t_q.month, t_q.year);
    assign now      = t_q;

    // Next calendar value after one millisecond, carrying upward.
    always_comb begin
        t_nxt = t_q;
        if (t_q.milli != 10'(MS_LAST)) begin
            t_nxt.milli = t_q.milli + 10'd1;
        end else begin
            t_nxt.milli = '0;
            if (t_q.second != 6'(SEC_LAST)) begin
                t_nxt.second = t_q.second + 6'd1;
            end else begin
                t_nxt.second = '0;
                if (t_q.minute != 6'(MIN_LAST)) begin
                    t_nxt.minute = t_q.minute + 6'd1;
                end else begin
                    t_nxt.minute = '0;
                    if (t_q.hour != 5'(HOUR_LAST)) begin
                        t_nxt.hour = t_q.hour + 5'd1;
                    end else begin
                        t_nxt.hour = '0;
                        if (t_q.day != last_day) begin
                            t_nxt.day = t_q.day + 5'd1;
                        end else begin
                            t_nxt.day = 5'd1;
                            if (t_q.month != 4'(MONTH_LAST)) begin
                                t_nxt.month = t_q.month + 4'd1;
                            end else begin
                                t_nxt.month = 4'd1;
                                t_nxt.year  = t_q.year + 16'd1;
                            end
                        end
                    end
                end
            end
        end
    end

    // Hold the time; load the default at power-on; advance on tick.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            t_q <= INIT_T;
        end else if (tick) begin
            t_q <= t_nxt;
        end
    end
endmodule

// File: rtl/cal_readport.sv
// Module cal_readport
// Byte read decoder with a coherent snapshot taken on offset-0 reads.
// Assumes bus inputs are synchronous to clk. Writes never reach any state.
module cal_readport
    import caltime_pkg::*;
#(
    parameter int        ADDR_W = 4,
    parameter cal_time_t INIT_T = '0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              bus_rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  cal_time_t         now,
    output logic [BYTE_W-1:0] rd_data
);
    cal_time_t         snap_q;
    cal_time_t         src;
    logic              access;
    logic              first;
    logic [BYTE_W-1:0] sel;
    logic [BYTE_W-1:0] rd_q;

    assign access  = rd_en && !wr_en && bus_rst_n;
    assign first   = (addr == '0);
    assign src     = first ? now : snap_q;
    assign rd_data = rd_q;

    // Pick the addressed byte; offset 0 reads the live value it snapshots.
    always_comb begin
        case (int'(addr))
            0:       sel = src.year[7:0];
            1:       sel = src.year[15:8];
            2:       sel = BYTE_W'(src.month);
            3:       sel = BYTE_W'(src.day);
            4:       sel = BYTE_W'(src.hour);
            5:       sel = BYTE_W'(src.minute);
            6:       sel = BYTE_W'(src.second);
            7:       sel = src.milli[7:0];
            8:       sel = BYTE_W'(src.milli[9:8]);
            default: sel = '0;
        endcase
    end

    // Capture every field on an offset-0 read.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            snap_q <= INIT_T;
        end else if (access && first) begin
            snap_q <= now;
        end
    end

    // Register read data; cleared by either reset, held when idle.
    always_ff @(posedge clk) begin
        if (!por_n || !bus_rst_n) begin
            rd_q <= '0;
        end else if (access) begin
            rd_q <= sel;
        end
    end
endmodule

// File: rtl/cal_clock_regs.sv
// Module cal_clock_regs
// Read-only calendar clock exposed as a nine-byte register window.
// Assumes por_n is asserted at start-up; bus_rst_n never touches the time.
module cal_clock_regs
    import caltime_pkg::*;
#(
    parameter int CYC_PER_MS    = 4,
    parameter int ADDR_W        = 4,
    parameter int INIT_YEAR     = 2024,
    parameter int INIT_MONTH    = 2,
    parameter int INIT_DAY      = 28,
    parameter int INIT_HOUR     = 23,
    parameter int INIT_MINUTE   = 59,
    parameter int INIT_SECOND   = 59,
    parameter int INIT_MILLI    = 990
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              bus_rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [7:0]        rd_data
);
    localparam cal_time_t INIT_T = '{
        year:   16'(INIT_YEAR),
        month:  4'(INIT_MONTH),
        day:    5'(INIT_DAY),
        hour:   5'(INIT_HOUR),
        minute: 6'(INIT_MINUTE),
        second: 6'(INIT_SECOND),
        milli:  10'(INIT_MILLI)
    };

    logic      tick;
    cal_time_t now_t;

    cal_prescaler #(.CYC_PER_MS(CYC_PER_MS)) u_pre (
        .clk   (clk),
        .por_n (por_n),
        .tick  (tick)
    );

    cal_counters #(.INIT_T(INIT_T)) u_cnt (
        .clk   (clk),
        .por_n (por_n),
        .tick  (tick),
        .now   (now_t)
    );

    cal_readport #(.ADDR_W(ADDR_W), .INIT_T(INIT_T)) u_rd (
        .clk       (clk),
        .por_n     (por_n),
        .bus_rst_n (bus_rst_n),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .addr      (addr),
        .now       (now_t),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/cal_clock_chk.sv
// Module cal_clock_chk
// Property checker for cal_clock_regs, attached by bind.
// Assumes por_n is low on the first edges; all checks are disabled during it.
module cal_clock_chk
    import caltime_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              por_n,
    input logic              bus_rst_n,
    input logic              rd_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        rd_data,
    input logic              tick,
    input cal_time_t         now
);
    AST_MONTH_RANGE: assert property (@(posedge clk) disable iff (!por_n)
        now.month >= 4'd1 && now.month <= 4'd12);                                  // R2
    AST_CLOCK_RANGE: assert property (@(posedge clk) disable iff (!por_n)
        now.hour <= 5'd23 && now.minute <= 6'd59 && now.second <= 6'd59);           // R2
    AST_MILLI_RANGE: assert property (@(posedge clk) disable iff (!por_n)
        now.milli <= 10'd999);                                                     // R3
    AST_DAY_LIMIT: assert property (@(posedge clk) disable iff (!por_n)
        now.day >= 5'd1 && now.day <= month_days(now.month, now.year));            // R5
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!por_n)
        !tick |=> $stable(now));                                                   // R4
    AST_TICK_ADVANCE: assert property (@(posedge clk) disable iff (!por_n)
        tick |=> !$stable(now.milli));                                             // R4
    AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rst_n && wr_en) |=> $stable(rd_data));                                // R8
    AST_BUS_RESET_CLEAR: assert property (@(posedge clk) disable iff (!por_n)
        !bus_rst_n |=> rd_data == 8'd0);                                           // R9
    AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rst_n && rd_en && !wr_en && int'(addr) > 8) |=> rd_data == 8'd0);     // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rst_n && !rd_en) |=> $stable(rd_data));                               // R11
endmodule

bind cal_clock_regs cal_clock_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .bus_rst_n (bus_rst_n),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .addr      (addr),
    .rd_data   (rd_data),
    .tick      (tick),
    .now       (now_t)
);

// File: tb/tb_cal_clock_regs.sv
`timescale 1ns/1ps
// Bench tb_cal_clock_regs: behavioural calendar model for two instances,
// compared on every clock, plus direct checks at leap day, year end and power-on.
module tb_cal_clock_regs;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       bus_rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] rd0, rd1;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #2 clk = ~clk;

    cal_clock_regs dut (
        .clk(clk), .por_n(por_n), .bus_rst_n(bus_rst_n),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .rd_data(rd0));

    cal_clock_regs #(.CYC_PER_MS(3), .INIT_YEAR(2023), .INIT_MONTH(12), .INIT_DAY(31),
        .INIT_HOUR(23), .INIT_MINUTE(59), .INIT_SECOND(59), .INIT_MILLI(995)) dut_ny (
        .clk(clk), .por_n(por_n), .bus_rst_n(bus_rst_n),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .rd_data(rd1));

    // Model configuration and state, index 0 = dut, 1 = dut_ny.
    int cyc[2]  = '{4, 3};
    int iy[2]   = '{2024, 2023};
    int imo[2]  = '{2, 12};
    int id[2]   = '{28, 31};
    int ims[2]  = '{990, 995};
    int y[2], mo[2], d[2], h[2], mi[2], s[2], ms[2], pre[2];
    int sy[2], smo[2], sd[2], sh[2], smi[2], ss[2], sms[2];
    int exp_rd[2];
    string tag[2];

    function automatic int dim(int m, int yr);
        if (m == 2) return (yr % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    function automatic int snap_byte(int i, int a);
        case (a)
            0: return sy[i] & 255;
            1: return (sy[i] >> 8) & 255;
            2: return smo[i];
            3: return sd[i];
            4: return sh[i];
            5: return smi[i];
            6: return ss[i];
            7: return sms[i] & 255;
            8: return (sms[i] >> 8) & 255;
            default: return 0;
        endcase
    endfunction

    // One millisecond of calendar progress (R4, R5).
    task automatic advance(int i);
        ms[i]++;
        if (ms[i] > 999) begin ms[i] = 0; s[i]++; end
        if (s[i] > 59) begin s[i] = 0; mi[i]++; end
        if (mi[i] > 59) begin mi[i] = 0; h[i]++; end
        if (h[i] > 23) begin h[i] = 0; d[i]++; end
        if (d[i] > dim(mo[i], y[i])) begin d[i] = 1; mo[i]++; end
        if (mo[i] > 12) begin mo[i] = 1; y[i] = (y[i] + 1) & 16'hffff; end
    endtask

    // Reference model step at every rising edge.
    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (!por_n) begin
                y[i] = iy[i]; mo[i] = imo[i]; d[i] = id[i];
                h[i] = 23; mi[i] = 59; s[i] = 59; ms[i] = ims[i]; pre[i] = 0;
                sy[i] = y[i]; smo[i] = mo[i]; sd[i] = d[i]; sh[i] = h[i];
                smi[i] = mi[i]; ss[i] = s[i]; sms[i] = ms[i];
                exp_rd[i] = 0; tag[i] = "R10";
            end else begin
                if (!bus_rst_n) begin
                    exp_rd[i] = 0; tag[i] = "R9";
                end else if (wr_en) begin
                    tag[i] = "R8";
                end else if (rd_en) begin
                    if (addr == 0) begin
                        sy[i] = y[i]; smo[i] = mo[i]; sd[i] = d[i]; sh[i] = h[i];
                        smi[i] = mi[i]; ss[i] = s[i]; sms[i] = ms[i];
                    end
                    exp_rd[i] = snap_byte(i, int'(addr));
                    if (addr <= 1) tag[i] = "R1";
                    else if (addr <= 6) tag[i] = "R2";
                    else if (addr == 7) tag[i] = "R3";
                    else if (addr == 8) tag[i] = "R6";
                    else tag[i] = "R7";
                end else begin
                    tag[i] = "R11";
                end
                if (pre[i] == cyc[i] - 1) begin pre[i] = 0; advance(i); end
                else pre[i]++;
            end
        end
    end

    task automatic check(string req, int act, int expv);
        compared++;
        if (act != expv) begin
            mismatched++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Per-clock comparison against the model, sampled on the falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check(tag[0], int'(rd0), exp_rd[0]);
            check(tag[1], int'(rd1), exp_rd[1]);
        end
    end

    task automatic drive(bit r, bit w, bit br, int a);
        @(negedge clk);
        rd_en = r; wr_en = w; bus_rst_n = br; addr = 4'(a);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        // Power-on reset; the reset state is compared (R10).
        repeat (3) @(negedge clk);
        cmp_on = 1;
        drive(0, 0, 0, 0);
        @(negedge clk);
        por_n = 1; bus_rst_n = 1;
        // Sequential byte reads across the leap day and year end.
        for (int k = 0; k < 72; k++) drive(1, 0, 1, k % 9);
        // Direct checks after midnight.
        drive(1, 0, 1, 0);
        drive(1, 0, 1, 3);
        check("R1", int'(rd0), 8'hE8);
        check("R1", int'(rd1), 8'hE8);
        drive(1, 0, 1, 2);
        check("R5", int'(rd0), 29);
        check("R4", int'(rd1), 1);
        drive(1, 0, 1, 1);
        check("R5", int'(rd0), 2);
        check("R4", int'(rd1), 1);
        drive(0, 0, 1, 0);
        check("R4", int'(rd1), 7);
        // Snapshot coherency: read offset 7 long after the offset-0 capture.
        repeat (10) drive(0, 0, 1, 0);
        drive(1, 0, 1, 7);
        drive(0, 0, 1, 0);
        check("R6", int'(rd0), exp_rd[0]);
        // Mixed stimulus: writes, bus resets, out-of-range reads, idle cycles.
        for (int k = 0; k < 400; k++) begin
            int a = $urandom % 16;
            bit r = ($urandom % 4) != 0;
            bit w = ($urandom % 5) == 0;
            bit br = ($urandom % 10) != 0;
            drive(r, w, br, a);
        end
        // Mid-run power-on reset reloads the defaults (R10).
        drive(0, 0, 1, 0);
        por_n = 0;
        drive(0, 0, 1, 0);
        drive(0, 0, 1, 0);
        por_n = 1;
        drive(1, 0, 1, 2);
        drive(0, 0, 1, 0);
        check("R10", int'(rd0), 2);
        check("R10", int'(rd1), 12);
        repeat (5) drive(0, 0, 1, 0);
        done = 1;
        summary();
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            mismatched++;
            $display("FAIL R4 watchdog: actual=running expected=finished");
            summary();
        end
    end
endmodule